// File: doc/BRIEF.md
# Cumulative Probability and Mean Prefix Unit

This block takes a full normalized histogram in one cycle. Each bin is an unsigned fraction with 24 bits. For every threshold k, the block returns two values. The first is the cumulative class probability, the sum of bins 0 through k. The second is the cumulative first moment, the sum of i times bin i over the same range. It also returns the global mean, which is the first moment taken over every bin. These are the inputs that a between-class variance stage needs for every candidate threshold at once.

Each bin is weighted by its own index using a constant gain. The gain is built only from shifts and adds. After the weighting, both the plain bins and the weighted bins pass through a registered parallel-prefix (Kogge-Stone) network. The network has log2(L) adder levels with a register after each level, so every prefix sum is produced in parallel and not by a running accumulation. The block accepts a new histogram on every cycle. A valid flag follows the data through the pipeline.

Top module: `cpm_prefix_unit`

## Requirements
- R1: While `rst_n` is low, and in the cycle after the edge that samples it low, `out_valid` is 0, whatever `in_valid` does.
- R2: Bin k is read from `in_bins[24k+23:24k]` as a 24-bit unsigned fraction. Result k is placed at `out_prob[24k+23:24k]`. When the sum of bins 0..k is at most 0xFFFFFF, this result equals that sum exactly.
- R3: When the sum of bins 0..k exceeds 0xFFFFFF, `out_prob` lane k saturates to 0xFFFFFF.
- R4: `out_mean[32k+31:32k]` equals the sum over i = 0..k of i times bin i, in an 8.24 unsigned format, taken modulo 2^32.
- R5: `out_gmean` equals the sum over all bins of i times bin i, modulo 2^32. This is the same value as mean lane L-1.
- R6: A histogram sampled with `in_valid` high at clock edge t appears on all outputs at once, with `out_valid` high, after edge t+LAT-1. Here LAT = 1 + clog2(L), which is 7 for the default L = 64.
- R7: A cycle with `in_valid` low produces a cycle with `out_valid` low LAT edges later. No `out_valid` pulse appears unless it was requested.
- R8: Histograms presented on consecutive cycles give independent results on consecutive cycles, at one result per cycle.
- R9: Whenever `out_valid` is high, the probability lanes never decrease as k rises.
- R10: Mean lane 0 is always 0, because bin 0 carries a weight of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_bins` as a histogram to process |
| in_bins | input | NUM_BINS*FRAC_W | Packed histogram bins, with bin 0 in the lowest bits |
| out_valid | output | 1 | Marks the outputs as a result |
| out_prob | output | NUM_BINS*FRAC_W | Cumulative probability per threshold, saturating |
| out_mean | output | NUM_BINS*(INT_W+FRAC_W) | Cumulative first moment per threshold, 8.24 format |
| out_gmean | output | INT_W+FRAC_W | Global mean, 8.24 format |

## Verification
All results of a histogram driven before edge t become visible just after edge t+LAT-1. For the default of 64 bins, that is seven register stages: one stage for input capture and weighting, then six prefix levels. Stimulus is driven on the falling edge, and each driven histogram is kept in a ring of past inputs. On every falling edge, the bench compares the outputs with the histogram it drove exactly LAT cycles earlier. This comparison covers `out_valid` as well as the data, so a result that arrives one cycle early or late fails both the valid check and the data check. Bubbles, back-to-back vectors and saturating vectors are mixed in the same stream, so the fixed-delay alignment is tested under every input pattern.

// File: rtl/cpm_pkg.sv
// Package: default widths shared by the cumulative prefix unit and its bench.
// Assumes bins are unsigned fractions and that the moment format is 8.24.
package cpm_pkg;
    localparam int DEF_BINS   = 64;  // number of histogram bins (L)
    localparam int DEF_FRAC_W = 24;  // fractional bits of bins and sums
    localparam int DEF_INT_W  = 8;   // integer bits of the moment format
endpackage

// File: rtl/cpm_gain.sv
// Constant index gain: multiplies one bin by the fixed value IDX using only
// shifts and adds, one term per set bit of IDX. The result is truncated to
// OUT_W bits. Assumes IN_W <= OUT_W. Purely combinational.
module cpm_gain #(
    parameter int IDX   = 0,
    parameter int IN_W  = 24,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  bin_in,
    output logic [OUT_W-1:0] weighted
);
    logic [OUT_W-1:0] ext;
    assign ext = {{(OUT_W-IN_W){1'b0}}, bin_in};

    // Sum the shifted copies selected by the constant's bits.
    always_comb begin
        weighted = '0;
        for (int b = 0; b < OUT_W; b++) begin
            if (((IDX >> b) & 1) == 1)
                weighted = weighted + (ext << b);
        end
    end
endmodule

// File: rtl/cpm_prefix_level.sv
// One registered level of a Kogge-Stone prefix adder: lane k adds lane k-DIST
// when it exists and otherwise passes its value through. Assumes the caller
// sizes WIDTH wide enough for the sums it expects; sums wrap modulo 2^WIDTH.
module cpm_prefix_level #(
    parameter int WIDTH = 32,
    parameter int COUNT = 64,
    parameter int DIST  = 1
) (
    input  logic                   clk,
    input  logic [COUNT*WIDTH-1:0] d_in,
    output logic [COUNT*WIDTH-1:0] q_out
);
    logic [COUNT*WIDTH-1:0] nxt;

    for (genvar k = 0; k < COUNT; k++) begin : g_lane
        if (k >= DIST) begin : g_add
            assign nxt[k*WIDTH +: WIDTH] = d_in[k*WIDTH +: WIDTH] + d_in[(k-DIST)*WIDTH +: WIDTH];
        end else begin : g_pass
            assign nxt[k*WIDTH +: WIDTH] = d_in[k*WIDTH +: WIDTH];
        end
    end

    // Register the level's result.
    always_ff @(posedge clk) begin
        q_out <= nxt;
    end
endmodule

// File: rtl/cpm_prefix_unit.sv
// Cumulative probability and first-moment prefix unit. It captures L bins,
// weights each bin by its index, then runs log2(L) registered prefix levels
// on both paths. The probability path is widened by log2(L) bits and
// saturates to the largest fraction at the output. Assumes NUM_BINS is a
// power of two, at least 2, and no greater than 2^INT_W.
module cpm_prefix_unit #(
    parameter int NUM_BINS = cpm_pkg::DEF_BINS,
    parameter int FRAC_W   = cpm_pkg::DEF_FRAC_W,
    parameter int INT_W    = cpm_pkg::DEF_INT_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [NUM_BINS*FRAC_W-1:0]          in_bins,
    output logic                                out_valid,
    output logic [NUM_BINS*FRAC_W-1:0]          out_prob,
    output logic [NUM_BINS*(INT_W+FRAC_W)-1:0]  out_mean,
    output logic [INT_W+FRAC_W-1:0]             out_gmean
);
    localparam int LEVELS = $clog2(NUM_BINS);
    localparam int LAT    = LEVELS + 1;
    localparam int PACC_W = FRAC_W + LEVELS;
    localparam int MEAN_W = INT_W + FRAC_W;
    localparam int CNT_W  = $clog2(LAT + 1);

    logic [NUM_BINS*PACC_W-1:0] p_in;
    logic [NUM_BINS*MEAN_W-1:0] m_in;
    logic [NUM_BINS*PACC_W-1:0] p_lvl [0:LEVELS];
    logic [NUM_BINS*MEAN_W-1:0] m_lvl [0:LEVELS];
    logic [LAT-1:0]             vpipe;

    // Per-bin widening for the probability path and index weighting for the mean path.
    for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
        assign p_in[k*PACC_W +: PACC_W] = {{LEVELS{1'b0}}, in_bins[k*FRAC_W +: FRAC_W]};
        cpm_gain #(.IDX(k), .IN_W(FRAC_W), .OUT_W(MEAN_W)) u_gain (
            .bin_in   (in_bins[k*FRAC_W +: FRAC_W]),
            .weighted (m_in[k*MEAN_W +: MEAN_W])
        );
    end

    // Input capture stage for both paths.
    always_ff @(posedge clk) begin
        p_lvl[0] <= p_in;
        m_lvl[0] <= m_in;
    end

    // Prefix levels with doubling distance.
    for (genvar j = 0; j < LEVELS; j++) begin : g_level
        cpm_prefix_level #(.WIDTH(PACC_W), .COUNT(NUM_BINS), .DIST(1 << j)) u_plev (
            .clk (clk), .d_in (p_lvl[j]), .q_out (p_lvl[j+1])
        );
        cpm_prefix_level #(.WIDTH(MEAN_W), .COUNT(NUM_BINS), .DIST(1 << j)) u_mlev (
            .clk (clk), .d_in (m_lvl[j]), .q_out (m_lvl[j+1])
        );
    end

    // Valid flag shifts alongside the data; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-2:0], in_valid};
    end
    assign out_valid = vpipe[LAT-1];

    // Saturate each probability lane to the largest fraction on overflow.
    for (genvar k = 0; k < NUM_BINS; k++) begin : g_out
        logic [PACC_W-1:0] praw;
        assign praw = p_lvl[LEVELS][k*PACC_W +: PACC_W];
        assign out_prob[k*FRAC_W +: FRAC_W] = (|praw[PACC_W-1:FRAC_W]) ? {FRAC_W{1'b1}} : praw[FRAC_W-1:0];
    end

    assign out_mean  = m_lvl[LEVELS];
    assign out_gmean = m_lvl[LEVELS][(NUM_BINS-1)*MEAN_W +: MEAN_W];

    // ---------------- assertions ----------------
    // Counts idle input cycles, saturating at LAT, for the no-spurious-valid check.
    logic [CNT_W-1:0] idle_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || in_valid)             idle_cnt <= '0;
        else if (idle_cnt != CNT_W'(LAT))   idle_cnt <= idle_cnt + 1'b1;
    end

    // R7: after LAT idle input cycles, no valid result may appear.
    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == CNT_W'(LAT)) |-> !out_valid);

    // R10: zero weight on bin 0 keeps mean lane 0 at zero.
    assert_mean_lane0_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mean[MEAN_W-1:0] == '0));

    // R4: mean lane 1 equals bin 1, which is the probability step from lane 0 to lane 1.
    assert_mean_lane1_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prob[2*FRAC_W-1:FRAC_W] != {FRAC_W{1'b1}}) |->
        (out_mean[2*MEAN_W-1:MEAN_W] == MEAN_W'(out_prob[2*FRAC_W-1:FRAC_W] - out_prob[FRAC_W-1:0])));

    // R9: cumulative probability is monotonic across lanes.
    for (genvar k = 1; k < NUM_BINS; k++) begin : g_mono
        assert_prob_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_prob[k*FRAC_W +: FRAC_W] >= out_prob[(k-1)*FRAC_W +: FRAC_W]));
    end
endmodule

// File: tb/cpm_prefix_unit_bench.sv
`timescale 1ns/1ps
module cpm_prefix_unit_bench;
    localparam int L      = 64;
    localparam int FW     = 24;
    localparam int MW     = 32;
    localparam int LAT    = $clog2(L) + 1;
    localparam int NVEC   = 400;
    localparam logic [FW-1:0] FMAX = {FW{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [L*FW-1:0]   in_bins = '0;
    logic              out_valid;
    logic [L*FW-1:0]   out_prob;
    logic [L*MW-1:0]   out_mean;
    logic [MW-1:0]     out_gmean;

    int checks = 0;
    int errors = 0;
    logic [L*FW-1:0] h_bins [0:15];
    logic            h_v    [0:15];

    always #2.5 clk = ~clk;

    cpm_prefix_unit #(.NUM_BINS(L), .FRAC_W(FW), .INT_W(8)) u_cpm_prefix_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bins(in_bins),
        .out_valid(out_valid), .out_prob(out_prob), .out_mean(out_mean), .out_gmean(out_gmean)
    );

    function automatic longint raw_sum(input logic [L*FW-1:0] b, input int k);
        longint s = 0;
        for (int i = 0; i <= k; i++) s += longint'(b[i*FW +: FW]);
        return s;
    endfunction

    function automatic logic [FW-1:0] exp_prob(input logic [L*FW-1:0] b, input int k);
        longint s = raw_sum(b, k);
        return (s > longint'(FMAX)) ? FMAX : s[FW-1:0];
    endfunction

    function automatic logic [MW-1:0] exp_mean(input logic [L*FW-1:0] b, input int k);
        longint s = 0;
        for (int i = 0; i <= k; i++) s += longint'(i) * longint'(b[i*FW +: FW]);
        return s[MW-1:0];
    endfunction

    task automatic check_out(input logic ev, input logic [L*FW-1:0] b);
        checks++;
        if (out_valid !== ev) begin
            errors++;
            $display("FAIL R6/R7 valid: actual %0b expected %0b", out_valid, ev);
        end
        if (ev) begin
            int bad_k;
            bad_k = -1;
            checks++;
            for (int k = L-1; k >= 0; k--) if (out_prob[k*FW +: FW] !== exp_prob(b, k)) bad_k = k;
            if (bad_k >= 0) begin
                errors++;
                $display("FAIL %s prob lane %0d: actual %h expected %h",
                         (raw_sum(b, bad_k) > longint'(FMAX)) ? "R3" : "R2",
                         bad_k, out_prob[bad_k*FW +: FW], exp_prob(b, bad_k));
            end
            bad_k = -1;
            checks++;
            for (int k = L-1; k >= 0; k--) if (out_mean[k*MW +: MW] !== exp_mean(b, k)) bad_k = k;
            if (bad_k >= 0) begin
                errors++;
                $display("FAIL R4 mean lane %0d: actual %h expected %h",
                         bad_k, out_mean[bad_k*MW +: MW], exp_mean(b, bad_k));
            end
            checks++;
            if (out_gmean !== exp_mean(b, L-1)) begin
                errors++;
                $display("FAIL R5 global mean: actual %h expected %h", out_gmean, exp_mean(b, L-1));
            end
        end
    endtask

    // Builds the stimulus for cycle c: directed corners first, then random mix (R8 back-to-back).
    task automatic make_vec(input int c, output logic v, output logic [L*FW-1:0] b);
        int mode;
        b = '0;
        v = 1'b1;
        case (c)
            0: ;                                                    // all zero
            1: b[(L-1)*FW +: FW] = FMAX;                            // single max bin at top
            2: b[0 +: FW] = 24'h123456;                             // bin 0 only, R10
            3: begin b[0 +: FW] = 24'hFFFFF0; b[(L-1)*FW +: FW] = 24'h00000F; end // sum hits max, R2
            4: begin b[0 +: FW] = 24'hFFFFF0; b[(L-1)*FW +: FW] = 24'h000010; end // sum = 1.0, R3
            5: for (int i = 0; i < L; i++) b[i*FW +: FW] = FMAX;    // all max, R3
            6: v = 1'b0;                                            // bubble, R7
            default: begin
                mode = int'($urandom % 8);
                if (c >= NVEC || mode == 0) v = 1'b0;
                else if (mode <= 2)
                    for (int i = 0; i < L; i++) b[i*FW +: FW] = FW'($urandom);
                else
                    for (int i = 0; i < L; i++) b[i*FW +: FW] = FW'($urandom % ((1 << FW) / L));
            end
        endcase
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin h_v[i] = 1'b0; h_bins[i] = '0; end
        // R1: reset holds out_valid low even with in_valid requested.
        in_valid = 1'b1;
        for (int i = 0; i < LAT + 3; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1 reset valid: actual %0b expected 0", out_valid);
            end
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        for (int c = 0; c < NVEC + LAT + 4; c++) begin
            logic v;
            logic [L*FW-1:0] b;
            @(negedge clk);
            if (c >= LAT) check_out(h_v[(c-LAT) & 15], h_bins[(c-LAT) & 15]);
            else          check_out(1'b0, '0);
            make_vec(c, v, b);
            in_valid = v;
            in_bins  = b;
            h_v[c & 15]    = v;
            h_bins[c & 15] = b;
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule